// File: doc/BRIEF.md
# Short-Codeword Decode Cache

This block sits beside a multi-cycle, memory-based variable-length-code decoder. It answers lookups for the short codewords that give the distance between non-zero coefficients in a 4x4 block. Each lookup request carries the current bitstream window and a table index. The cache compares the leading bits of the window against a small set of stored entries. Each entry holds a codeword of at most four bits, the length of that codeword, the decoded symbol and the table the codeword belongs to. On a hit, the cache returns the symbol and length one cycle after the request and keeps the main decoder idle. On a miss, it pulses an enable that starts the main decoder, and it remembers the missed window prefix and table.

When the main decoder has produced its result, the controller raises the write strobe. The cache then stores that symbol and length, together with the remembered prefix and table, in the lowest-numbered free entry. Entries are never evicted. Once all of them are valid, further fills are dropped, and results longer than the cache's codeword width are never stored.

The lookup and fill strobes are plain single-cycle controls with no back-pressure. A response is valid for exactly one cycle. The consumer must take it in that cycle, because the cache does not hold it or retry it.

Top module: `short_vlc_cache`

## Requirements
- R1: After reset every entry is invalid: the first lookup misses, and no response or decoder enable is asserted before a lookup is made.
- R2: A lookup hits only on a valid entry whose table index equals `tbl_idx` and whose stored codeword equals the top L bits of `win`, where L is that entry's stored length (bit `WIN_W-1` is the first bitstream bit).
- R3: A lookup made with `read_en` at clock edge t produces `rsp_valid` high for exactly the cycle after edge t. On a hit, `rsp_hit` is 1, `rsp_sym` is the stored symbol, `rsp_len` is the stored length, and `dec_en` stays low.
- R4: On a miss, `rsp_hit` is 0 and `dec_en` is high in the same single cycle as `rsp_valid`. `dec_en` is never high at any other time.
- R5: Every miss records the top `CW_MAX` bits of the window and the table index, replacing any earlier record. A following `write_en` stores `dec_sym` and `dec_len`, with the recorded table and the top `dec_len` recorded bits, in the lowest-numbered invalid entry. The stored entry is visible to lookups from the next edge on.
- R6: A fill whose `dec_len` is 0 or greater than `CW_MAX` (4) stores nothing.
- R7: When all `N_ENT` entries are valid, a fill stores nothing and no existing entry changes: entries are never replaced.
- R8: Each `write_en` consumes the miss record. A `write_en` with no miss recorded since the last one stores nothing.
- R9: When several entries match one lookup, the lowest-numbered entry supplies the symbol and length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| read_en | input | 1 | Lookup strobe from the controller |
| win | input | WIN_W (16) | Bitstream window; MSB is the next bit |
| tbl_idx | input | TBL_W (3) | Table the codeword is decoded with |
| write_en | input | 1 | Fill strobe from the controller |
| dec_sym | input | SYM_W (8) | Symbol returned by the main decoder |
| dec_len | input | LEN_W (5) | Codeword length returned by the main decoder |
| dec_en | output | 1 | Starts the main decoder after a miss |
| rsp_valid | output | 1 | Lookup response valid (one cycle) |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_sym | output | SYM_W (8) | Symbol on a hit |
| rsp_len | output | LEN_W (5) | Codeword length on a hit |

## Verification
Two states are the hardest to reach from the ports. The first is the full cache with its no-replacement behaviour. The bench gets there by running a miss-then-fill pair for each remaining entry, using four-bit codewords under a table that no earlier entry uses, so that each new probe is certain to miss. It then shows that a further fill is dropped and that the oldest entries still hit. The second is an overlapping match for the lowest-index rule. The bench builds it by storing a three-bit codeword and, later, a two-bit prefix of it under the same table, so that one window matches both entries. Stale fills are checked by observing whether a window that a stale entry would catch still misses.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int DEF_WIN_W  = 16;
  localparam int DEF_TBL_W  = 3;
  localparam int DEF_SYM_W  = 8;
  localparam int DEF_LEN_W  = 5;
  localparam int DEF_N_ENT  = 8;
  localparam int DEF_CW_MAX = 4;

  // State of the single miss record kept between lookup and fill.
  typedef enum logic {
    REC_EMPTY = 1'b0,
    REC_HELD  = 1'b1
  } rec_state_e;
endpackage

// File: rtl/svc_first.sv
module svc_first #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  // Lowest set bit wins.
  assign gnt = req & (~req + N'(1));
  assign any = |req;
endmodule

// File: rtl/svc_entry.sv
module svc_entry #(
  parameter int TBL_W = 3,
  parameter int CW_W  = 4,
  parameter int SYM_W = 8,
  localparam int ELEN_W = $clog2(CW_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [TBL_W-1:0]  wr_tbl,
  input  logic [CW_W-1:0]   wr_code,
  input  logic [ELEN_W-1:0] wr_len,
  input  logic [SYM_W-1:0]  wr_sym,
  input  logic [TBL_W-1:0]  look_tbl,
  input  logic [CW_W-1:0]   look_top,
  output logic              vld,
  output logic              match,
  output logic [SYM_W-1:0]  sym,
  output logic [ELEN_W-1:0] len
);
  logic [TBL_W-1:0] e_tbl;
  logic [CW_W-1:0]  e_code;
  logic [CW_W-1:0]  e_mask;
  logic [CW_W-1:0]  w_mask;

  // Left-aligned masks: the top 'len' bits are significant.
  always_comb begin
    for (int b = 0; b < CW_W; b++) begin
      e_mask[CW_W-1-b] = (ELEN_W'(b) < len);
      w_mask[CW_W-1-b] = (ELEN_W'(b) < wr_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      e_tbl  <= '0;
      e_code <= '0;
      len    <= '0;
      sym    <= '0;
    end else if (wr && !vld) begin
      vld    <= 1'b1;
      e_tbl  <= wr_tbl;
      e_code <= wr_code & w_mask;
      len    <= wr_len;
      sym    <= wr_sym;
    end
  end

  assign match = vld && (e_tbl == look_tbl) && ((look_top & e_mask) == e_code);
endmodule

// File: rtl/short_vlc_cache.sv
module short_vlc_cache
  import svc_pkg::*;
#(
  parameter int WIN_W  = DEF_WIN_W,
  parameter int TBL_W  = DEF_TBL_W,
  parameter int SYM_W  = DEF_SYM_W,
  parameter int LEN_W  = DEF_LEN_W,
  parameter int N_ENT  = DEF_N_ENT,
  parameter int CW_MAX = DEF_CW_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             read_en,
  input  logic [WIN_W-1:0] win,
  input  logic [TBL_W-1:0] tbl_idx,
  input  logic             write_en,
  input  logic [SYM_W-1:0] dec_sym,
  input  logic [LEN_W-1:0] dec_len,
  output logic             dec_en,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [SYM_W-1:0] rsp_sym,
  output logic [LEN_W-1:0] rsp_len
);
  localparam int ELEN_W = $clog2(CW_MAX + 1);

  logic [CW_MAX-1:0] look_top;
  logic [N_ENT-1:0]  ent_vld;
  logic [N_ENT-1:0]  ent_match;
  logic [N_ENT-1:0]  hit_gnt;
  logic [N_ENT-1:0]  free_gnt;
  logic [N_ENT-1:0]  ent_wr;
  logic              any_hit;
  logic              any_free;
  logic [SYM_W-1:0]  ent_sym [N_ENT];
  logic [ELEN_W-1:0] ent_len [N_ENT];
  logic [SYM_W-1:0]  sel_sym;
  logic [ELEN_W-1:0] sel_len;

  rec_state_e        rec_q;
  logic [CW_MAX-1:0] rec_code_q;
  logic [TBL_W-1:0]  rec_tbl_q;
  logic              len_ok;
  logic              fill_ok;

  assign look_top = win[WIN_W-1 -: CW_MAX];

  genvar gi;
  generate
    for (gi = 0; gi < N_ENT; gi++) begin : g_ent
      svc_entry #(
        .TBL_W(TBL_W),
        .CW_W (CW_MAX),
        .SYM_W(SYM_W)
      ) u_ent (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ent_wr[gi]),
        .wr_tbl  (rec_tbl_q),
        .wr_code (rec_code_q),
        .wr_len  (ELEN_W'(dec_len)),
        .wr_sym  (dec_sym),
        .look_tbl(tbl_idx),
        .look_top(look_top),
        .vld     (ent_vld[gi]),
        .match   (ent_match[gi]),
        .sym     (ent_sym[gi]),
        .len     (ent_len[gi])
      );
    end
  endgenerate

  svc_first #(.N(N_ENT)) u_hit_sel (
    .req(ent_match),
    .gnt(hit_gnt),
    .any(any_hit)
  );

  svc_first #(.N(N_ENT)) u_free_sel (
    .req(~ent_vld),
    .gnt(free_gnt),
    .any(any_free)
  );

  always_comb begin
    sel_sym = '0;
    sel_len = '0;
    for (int i = 0; i < N_ENT; i++) begin
      sel_sym = sel_sym | ({SYM_W{hit_gnt[i]}} & ent_sym[i]);
      sel_len = sel_len | ({ELEN_W{hit_gnt[i]}} & ent_len[i]);
    end
  end

  // Fill qualification: a held record, a short non-zero length, a free slot.
  assign len_ok  = (dec_len != '0) && (dec_len <= LEN_W'(CW_MAX));
  assign fill_ok = write_en && (rec_q == REC_HELD) && len_ok && any_free;
  assign ent_wr  = free_gnt & {N_ENT{fill_ok}};

  // Response and decoder-enable registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      dec_en    <= 1'b0;
      rsp_sym   <= '0;
      rsp_len   <= '0;
    end else begin
      rsp_valid <= read_en;
      rsp_hit   <= read_en && any_hit;
      dec_en    <= read_en && !any_hit;
      if (read_en && any_hit) begin
        rsp_sym <= sel_sym;
        rsp_len <= LEN_W'(sel_len);
      end
    end
  end

  // Miss record: a new miss overrides; a fill strobe consumes it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q      <= REC_EMPTY;
      rec_code_q <= '0;
      rec_tbl_q  <= '0;
    end else if (read_en && !any_hit) begin
      rec_q      <= REC_HELD;
      rec_code_q <= look_top;
      rec_tbl_q  <= tbl_idx;
    end else if (write_en) begin
      rec_q      <= REC_EMPTY;
    end
  end
endmodule

// File: rtl/svc_checker.sv
module svc_checker #(
  parameter int LEN_W  = 5,
  parameter int CW_MAX = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             read_en,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [LEN_W-1:0] rsp_len,
  input logic             dec_en
);
  p_resp_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    read_en |=> rsp_valid);

  p_quiet_without_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !read_en |=> !rsp_valid);

  p_hit_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid && !dec_en);

  p_dec_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> dec_en);

  p_dec_only_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> (rsp_valid && !rsp_hit));

  p_hit_len_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_len != '0 && rsp_len <= LEN_W'(CW_MAX)));
endmodule

bind short_vlc_cache svc_checker #(.LEN_W(LEN_W), .CW_MAX(CW_MAX)) u_svc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .read_en  (read_en),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .rsp_len  (rsp_len),
  .dec_en   (dec_en)
);

// File: tb/short_vlc_cache_bench.sv
`timescale 1ns/1ps
module short_vlc_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        read_en = 1'b0;
  logic [15:0] win = '0;
  logic [2:0]  tbl_idx = '0;
  logic        write_en = 1'b0;
  logic [7:0]  dec_sym = '0;
  logic [4:0]  dec_len = '0;
  logic        dec_en, rsp_valid, rsp_hit;
  logic [7:0]  rsp_sym;
  logic [4:0]  rsp_len;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic       hit;
    logic [7:0] sym;
    logic [4:0] len;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  short_vlc_cache u_short_vlc_cache (
    .clk(clk), .rst_n(rst_n), .read_en(read_en), .win(win), .tbl_idx(tbl_idx),
    .write_en(write_en), .dec_sym(dec_sym), .dec_len(dec_len), .dec_en(dec_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_sym(rsp_sym), .rsp_len(rsp_len)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: one lookup per call, expected result pushed to the scoreboard.
  task automatic lookup(input logic [15:0] w, input logic [2:0] t, input logic hit,
                        input logic [7:0] sym, input logic [4:0] len, input string tag);
    exp_t e;
    e.hit = hit; e.sym = sym; e.len = len; e.tag = tag;
    q.push_back(e);
    read_en = 1'b1; win = w; tbl_idx = t;
    @(negedge clk);
    read_en = 1'b0;
  endtask

  task automatic fill(input logic [7:0] sym, input logic [4:0] len);
    write_en = 1'b1; dec_sym = sym; dec_len = len;
    @(negedge clk);
    write_en = 1'b0;
  endtask

  // Monitor: compares each response against the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_hit == e.hit, {e.tag, " hit"}, rsp_hit, e.hit);
          chk(dec_en == !e.hit, {e.tag, " R4 dec_en"}, dec_en, !e.hit);
          if (e.hit) begin
            chk(rsp_sym == e.sym, {e.tag, " sym"}, rsp_sym, e.sym);
            chk(rsp_len == e.len, {e.tag, " len"}, rsp_len, e.len);
          end
        end
      end else begin
        chk(!dec_en, "R4 dec_en without response", dec_en, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !dec_en, "R1 outputs in reset", {rsp_valid, dec_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !dec_en, "R1 outputs after reset", {rsp_valid, dec_en}, 0);

    // R1: empty cache misses.
    lookup(16'hF000, 3'd1, 1'b0, 8'h00, 5'd0, "R1 first lookup");
    fill(8'h21, 5'd1);                                         // entry0: tbl1 "1"
    lookup(16'h8000, 3'd1, 1'b1, 8'h21, 5'd1, "R3 hit len1");
    lookup(16'h8000, 3'd2, 1'b0, 8'h00, 5'd0, "R2 table mismatch");
    fill(8'h32, 5'd3);                                         // entry1: tbl2 "100"
    lookup(16'h9FFF, 3'd2, 1'b1, 8'h32, 5'd3, "R5 stored len3");
    lookup(16'hA000, 3'd2, 1'b0, 8'h00, 5'd0, "R2 codeword mismatch");
    fill(8'h44, 5'd5);                                         // too long, dropped
    lookup(16'hA000, 3'd2, 1'b0, 8'h00, 5'd0, "R6 long fill dropped");
    fill(8'h45, 5'd2);                                         // entry2: tbl2 "10"
    lookup(16'h8000, 3'd2, 1'b1, 8'h32, 5'd3, "R9 lowest index wins");
    lookup(16'hB000, 3'd2, 1'b1, 8'h45, 5'd2, "R5 stored len2");
    fill(8'h55, 5'd1);                                         // no record: ignored
    lookup(16'hC000, 3'd2, 1'b0, 8'h00, 5'd0, "R8 stale fill ignored");
    fill(8'h56, 5'd0);                                         // zero length
    lookup(16'hC000, 3'd2, 1'b0, 8'h00, 5'd0, "R6 zero-length fill dropped");
    fill(8'h57, 5'd0);                                         // consume record

    // Fill the remaining five entries back to back.
    for (int i = 0; i < 5; i++) begin
      lookup({i[3:0], 12'h0}, 3'd3, 1'b0, 8'h00, 5'd0, "R5 fill probe");
      fill(8'h60 + 8'(i), 5'd4);
    end
    lookup(16'h5000, 3'd3, 1'b0, 8'h00, 5'd0, "R7 probe when full");
    fill(8'h70, 5'd4);
    lookup(16'h5000, 3'd3, 1'b0, 8'h00, 5'd0, "R7 full fill dropped");
    lookup(16'h0000, 3'd3, 1'b1, 8'h60, 5'd4, "R7 entry kept");
    lookup(16'h4ABC, 3'd3, 1'b1, 8'h64, 5'd4, "R7 last entry");
    lookup(16'hFFFF, 3'd1, 1'b1, 8'h21, 5'd1, "R7 no replacement");
    lookup(16'h2000, 3'd3, 1'b1, 8'h62, 5'd4, "R3 back to back");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R3 responses outstanding", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule